// File: doc/BRIEF.md
# Cascadable Serial LED Channel Register

This block is the digital data path of a sixteen-channel sink-type LED driver. A host clocks a bit stream in on a slow serial clock. The block samples that clock and the other control pins into a fast system clock and advances a sixteen-stage shift register on every rising serial-clock edge. The last stage drives a serial output, so several drivers can be chained on one data line.

A level-sensitive latch copies the shift register for as long as the latch-enable pin is high. It freezes the pattern when the pin goes low. An active-high blanking pin forces every channel off. When blanking is released, each channel shows its latched bit, and a 1 turns that channel on. Adjacent channels change state a fixed number of system-clock cycles apart, so the current sinks never all switch at the same moment.

A synchronous active-high reset serves as the power-on clear. The analog current sinks, the current setting and any fault detection are outside this block.

Top module: `led_chan_reg`

## Requirements
- R1: Each rising edge of `ser_clk` shifts the register up by one place, and `ser_in` enters bit 0. Sixteen shifts of bits b15 first down to b0 leave the register holding b15..b0, with b0 in bit 0.
- R2: `ser_out` shows register bit 15 and changes only because of a shift. It is unchanged 2 system cycles after the `ser_clk` rising pin edge and shows the new value 3 cycles after it, so a chained device sees the first device's earlier contents, most significant bit first.
- R3: While `lat_en` is high, the latch follows the shift register, including shifts made during that time.
- R4: While `lat_en` is low, the latch keeps its contents whatever is shifted in.
- R5: While `blank` is high, every bit of `chan_on` is 0 whatever the latched data.
- R6: While `blank` is low, `chan_on[n]` equals latched bit n, where 1 means on.
- R7: After `blank` falls, channel n turns on 3 + n*LAG system cycles after the pin change (LAG defaults to 4 cycles, about 20 ns at 200 MHz).
- R8: After `blank` rises, channel n turns off with the same 3 + n*LAG cycle delay.
- R9: Reset clears the shift register and the latch. After reset, `chan_on` and `ser_out` are 0, and a latch pulse with blanking released still leaves every channel off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all logic runs on its rising edge |
| rst | input | 1 | Synchronous active-high reset (power-on clear) |
| ser_clk | input | 1 | Serial shift clock from the host; the rising edge shifts |
| ser_in | input | 1 | Serial data in |
| lat_en | input | 1 | Latch enable; transparent when high, holds when low |
| blank | input | 1 | Active-high output blanking |
| ser_out | output | 1 | Last shift stage, for the next device in the chain |
| chan_on | output | NCH | Per-channel sink enable, 1 = on |

## Verification
Every pin passes through two synchroniser flops. A shift therefore reaches `ser_out` on the third system edge after the `ser_clk` pin rises. A blanking change reaches channel n on edge 3 + n*LAG. The bench drives pins on falling clock edges and samples on the next falling edge after the due rising edge. For the stagger tests it compares the whole channel vector on every cycle against a mask built from those formulas, so a channel that switches one cycle early or late is caught. Steady-state checks of the vector table wait for a settle window longer than the slowest channel's delay before comparing.

// File: rtl/lcr_pkg.sv
package lcr_pkg;

  // Pin bundle carried through the synchroniser as one vector.
  typedef struct packed {
    logic sck;
    logic sdi;
    logic lat;
    logic blank;
  } lcr_pins_t;

  localparam int PIN_W = $bits(lcr_pins_t);

  // Delay-line depth, in system cycles, for a given channel.
  function automatic int lag_depth(input int ch, input int lag);
    return ch * lag;
  endfunction

endpackage

// File: rtl/lcr_sync.sv
module lcr_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);

  // One flop chain per bit.
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], d_async[b]};
    end
    assign q_sync[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/lcr_shift.sv
module lcr_shift #(
  parameter int NCH = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sck_s,
  input  logic           sdi_s,
  output logic [NCH-1:0] q,
  output logic           sout
);

  logic sck_prev;
  logic step;

  // Rising edge of the synchronised serial clock.
  assign step = sck_s & ~sck_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_prev <= 1'b0;
      q        <= '0;
    end else begin
      sck_prev <= sck_s;
      if (step) q <= {q[NCH-2:0], sdi_s};
    end
  end

  assign sout = q[NCH-1];

  // R1
  shift_adv_chk: assert property (@(posedge clk) disable iff (rst)
    step |=> (q == {$past(q[NCH-2:0]), $past(sdi_s)}));

  // R2
  sout_still_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(sout));

endmodule

// File: rtl/lcr_latch.sv
module lcr_latch #(
  parameter int NCH = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           lat_s,
  input  logic [NCH-1:0] d,
  output logic [NCH-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (lat_s) q <= d;
  end

  // R3
  latch_pass_chk: assert property (@(posedge clk) disable iff (rst)
    lat_s |=> (q == $past(d)));

  // R4
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !lat_s |=> $stable(q));

endmodule

// File: rtl/lcr_stagger.sv
module lcr_stagger #(
  parameter int NCH = 16,
  parameter int LAG = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] bits,
  input  logic           blank_s,
  output logic [NCH-1:0] chan
);
  import lcr_pkg::*;

  logic [NCH-1:0] gated;
  assign gated = bits & ~{NCH{blank_s}};

  // Channel n: n*LAG cycles of delay line plus one output register.
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam int D = lag_depth(ch, LAG);
    logic [D:0] line;
    if (D == 0) begin : g_direct
      always_ff @(posedge clk) begin
        if (rst) line <= '0;
        else     line <= gated[ch];
      end
    end else begin : g_delay
      always_ff @(posedge clk) begin
        if (rst) line <= '0;
        else     line <= {line[D-1:0], gated[ch]};
      end
    end
    assign chan[ch] = line[D];
  end

endmodule

// File: rtl/led_chan_reg.sv
module led_chan_reg #(
  parameter int NCH         = 16,
  parameter int LAG         = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ser_clk,
  input  logic           ser_in,
  input  logic           lat_en,
  input  logic           blank,
  output logic           ser_out,
  output logic [NCH-1:0] chan_on
);
  import lcr_pkg::*;

  localparam int OFF_CYC = 1 + (NCH - 1) * LAG;
  localparam int CNT_W   = $clog2(OFF_CYC + 2) + 1;

  lcr_pins_t pins_a, pins_s;
  logic [NCH-1:0] shift_q, latch_q;

  assign pins_a = '{sck: ser_clk, sdi: ser_in, lat: lat_en, blank: blank};

  lcr_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_async(pins_a), .q_sync(pins_s)
  );

  lcr_shift #(.NCH(NCH)) u_shift (
    .clk(clk), .rst(rst), .sck_s(pins_s.sck), .sdi_s(pins_s.sdi),
    .q(shift_q), .sout(ser_out)
  );

  lcr_latch #(.NCH(NCH)) u_latch (
    .clk(clk), .rst(rst), .lat_s(pins_s.lat), .d(shift_q), .q(latch_q)
  );

  lcr_stagger #(.NCH(NCH), .LAG(LAG)) u_stag (
    .clk(clk), .rst(rst), .bits(latch_q), .blank_s(pins_s.blank),
    .chan(chan_on)
  );

  // Counts the cycles blanking has been held, for the check below.
  logic [CNT_W-1:0] blank_run;
  always_ff @(posedge clk) begin
    if (rst || !pins_s.blank)       blank_run <= '0;
    else if (blank_run < CNT_W'(OFF_CYC + 1)) blank_run <= blank_run + 1'b1;
  end

  // R5
  blank_all_off_chk: assert property (@(posedge clk) disable iff (rst)
    (blank_run >= CNT_W'(OFF_CYC)) |-> (chan_on == '0));

  // R9
  rst_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (chan_on == '0 && ser_out == 1'b0));

endmodule

// File: tb/led_chan_reg_test.sv
`timescale 1ns/1ps
module led_chan_reg_test;
  localparam int NCH    = 16;
  localparam int LAG    = 4;
  localparam int SETTLE = 3 + (NCH - 1) * LAG + 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_in = 1'b0, lat_en = 1'b0, blank = 1'b1;
  logic ser_out;
  logic [NCH-1:0] chan_on;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  led_chan_reg #(.NCH(NCH), .LAG(LAG), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_in(ser_in),
    .lat_en(lat_en), .blank(blank), .ser_out(ser_out), .chan_on(chan_on)
  );

  // {pattern, blank, expected chan_on}
  localparam logic [32:0] VEC [6] = '{
    {16'hA5C3, 1'b0, 16'hA5C3},
    {16'hFFFF, 1'b0, 16'hFFFF},
    {16'h8001, 1'b0, 16'h8001},
    {16'h1234, 1'b1, 16'h0000},
    {16'h0000, 1'b0, 16'h0000},
    {16'h7FFE, 1'b0, 16'h7FFE}
  };

  task automatic cyc(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [NCH-1:0] act,
                     input logic [NCH-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    ser_in = b; ser_clk = 1'b0;
    cyc(3);
    ser_clk = 1'b1;
    cyc(3);
  endtask

  task automatic shift_word(input logic [NCH-1:0] w);
    for (int i = NCH - 1; i >= 0; i--) shift_bit(w[i]);
  endtask

  task automatic pulse_latch();
    lat_en = 1'b1; cyc(4); lat_en = 1'b0; cyc(3);
  endtask

  // Watchdog
  initial begin
    cyc(150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [NCH-1:0] exp_m;
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R9 reset state
    chk("R9 reset chan_on", chan_on, '0);
    chk("R9 reset ser_out", {15'd0, ser_out}, '0);

    // Vector table: R1, R2, R3, R5, R6
    for (int v = 0; v < 6; v++) begin
      logic [NCH-1:0] pat, exp;
      logic           bl;
      {pat, bl, exp} = VEC[v];
      blank = 1'b1;
      shift_word(pat);
      chk("R2 ser_out is bit15", {15'd0, ser_out}, {15'd0, pat[NCH-1]});
      pulse_latch();
      blank = bl;
      cyc(SETTLE);
      chk(bl ? "R5 blanked" : "R1/R3/R6 pattern shown", chan_on, exp);
    end

    // R2 shift latency and cascade order
    blank = 1'b1; cyc(SETTLE);
    shift_word(16'h9C4B);
    for (int j = 0; j < NCH; j++) begin
      logic [NCH-1:0] nxt;
      nxt = 16'h9C4B << (j + 1);
      chk("R2 cascade order", {15'd0, ser_out}, {15'd0, 16'h9C4B >> (15 - j)} & 16'h1);
      ser_in = 1'b0; ser_clk = 1'b0; cyc(3);
      ser_clk = 1'b1;
      cyc(2);
      chk("R2 unchanged at 2", {15'd0, ser_out}, {15'd0, (16'h9C4B >> (15 - j)) & 16'h1} & 16'h1);
      cyc(1);
      chk("R2 updated at 3", {15'd0, ser_out}, {15'd0, nxt[NCH-1]});
    end
    // register now all zero

    // R7 staggered turn-on
    shift_word(16'hFFFF);
    pulse_latch();
    blank = 1'b0;
    for (int k = 1; k <= SETTLE; k++) begin
      cyc(1);
      exp_m = '0;
      for (int n = 0; n < NCH; n++) exp_m[n] = (k >= 3 + n * LAG);
      chk("R7 turn-on stagger", chan_on, exp_m);
    end

    // R8 staggered turn-off
    blank = 1'b1;
    for (int k = 1; k <= SETTLE; k++) begin
      cyc(1);
      exp_m = '0;
      for (int n = 0; n < NCH; n++) exp_m[n] = (k < 3 + n * LAG);
      chk("R8 turn-off stagger", chan_on, exp_m);
    end

    // R3 transparent latch follows a shift made while open
    blank = 1'b0;
    shift_word(16'h00F0);
    pulse_latch();
    cyc(SETTLE);
    chk("R6 shown", chan_on, 16'h00F0);
    lat_en = 1'b1;
    shift_bit(1'b1);
    cyc(SETTLE);
    chk("R3 transparent", chan_on, 16'h01E1);
    lat_en = 1'b0; cyc(3);

    // R4 hold while closed
    shift_word(16'h5A5A);
    cyc(SETTLE);
    chk("R4 hold", chan_on, 16'h01E1);

    // R9 reset mid-operation clears shift register and latch
    rst = 1'b1; cyc(2); rst = 1'b0; cyc(1);
    chk("R9 cleared chan_on", chan_on, '0);
    chk("R9 cleared ser_out", {15'd0, ser_out}, '0);
    pulse_latch();
    cyc(SETTLE);
    chk("R9 latch empty", chan_on, '0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule